// File: doc/BRIEF.md
# General-Purpose I/O Bank with Edge and Level Interrupts

This block is a bank of up to 32 general-purpose pins controlled through a flat register port. Each pin has a direction bit, an output value and a blink enable. An output pin can either follow its value bit or toggle on its own at a rate set by a prescaler. Every pin is sampled through a two-stage synchroniser. The sample is then XORed with a per-pin polarity bit, and that adjusted value is what software reads and what the interrupt logic watches.

A rising transition of the adjusted value latches a per-pin edge-cause bit. Writing a zero to a cause bit clears it, and writing a one leaves it as it is. One interrupt output merges two masked terms: the adjusted levels ANDed with the level mask, and the latched causes ANDed with the edge mask. Software catches falling edges or active-low levels only by setting polarity. Software catches both edges by flipping polarity after each event. A polarity flip that raises the adjusted value counts as an edge.

Top module: `gpio_bank`

## Requirements
- R1: In reset all pins are inputs (pin_oe_o all 0). The output value, blink, polarity, edge-cause and both mask registers read 0, and the direction register reads all ones.
- R2: The output value register is at byte address 0x00 and the direction register is at 0x04. A direction bit of 1 makes the pin an input (oe 0). A direction bit of 0 enables the driver (oe 1), and when blink is off pin_o follows the output value bit.
- R3: The data-in register at 0x10 returns each synchronised pin level XORed with its polarity bit, where polarity is at 0x0C. A pin change appears two clock edges after it is applied. Writes to 0x10 have no effect.
- R4: irq_o is the OR over all pins of (data-in AND level mask) OR (edge cause AND edge mask). The edge mask is at 0x18+MASK_OFS and the level mask is at 0x1C+MASK_OFS.
- R5: A write to the edge-cause register at 0x14 clears each bit written as 0 and keeps each bit written as 1.
- R6: An edge-cause bit sets on a 0-to-1 transition of the adjusted input, one clock edge after data-in shows the new value. A 1-to-0 transition sets nothing.
- R7: A polarity write that raises a pin's adjusted value while the pin is stable sets that pin's edge cause. With polarity 1, a falling pin sets its cause.
- R8: With blink set on an output pin, pin_o toggles every BLINK_DIV clock cycles regardless of the output value. With blink clear it holds steady between register writes.
- R9: When a cause bit is cleared by a write in the same cycle that a rising transition sets it, the bit ends up set.
- R10: Addresses that map to no register read 0. This includes 0x18 and 0x1C when MASK_OFS is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NUM_PINS | Pin levels from the pads |
| pin_o | output | NUM_PINS | Values driven to the pads |
| pin_oe_o | output | NUM_PINS | Per-pin output enable |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The assertions take for granted that the pins are held low through reset. This keeps the synchroniser from producing a rising transition in the first cycles. They also assume the register addresses, moved by MASK_OFS, do not collide. The stimulus drives pins and register strobes only on the falling clock edge, one write per cycle, and keeps every input at a known value. Pins are driven low whenever reset is asserted, and MASK_OFS is set to 0x20, which stays clear of every other register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_OUT   = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_BLINK = 32'h08;
  localparam int unsigned OFS_POL   = 32'h0C;
  localparam int unsigned OFS_DIN   = 32'h10;
  localparam int unsigned OFS_CAUSE = 32'h14;
  localparam int unsigned OFS_EMASK = 32'h18;
  localparam int unsigned OFS_LMASK = 32'h1C;
  localparam int unsigned DATA_W    = 32;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] prev_q, cause_q, cause_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // rising transition wins over a same-cycle clear
    assign cause_d[i] = (din_i[i] & ~prev_q[i]) |
                        (cause_q[i] & ~(wr_i & ~keep_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din_i;
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MASK_OFS  = 0,
  parameter int unsigned BLINK_DIV = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned N = NUM_PINS;
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(OFS_EMASK + MASK_OFS);
  localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(OFS_LMASK + MASK_OFS);

  logic [N-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [N-1:0] wd, sync, din, cause;
  logic         phase;
  logic         wr_cause;

  assign wd       = wdata_i[N-1:0];
  assign wr_cause = we_i && (addr_i == A_CAUSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_OUT)   out_q   <= wd;
      if (addr_i == A_DIR)   dir_q   <= wd;
      if (addr_i == A_BLINK) blink_q <= wd;
      if (addr_i == A_POL)   pol_q   <= wd;
      if (addr_i == A_EMASK) emask_q <= wd;
      if (addr_i == A_LMASK) lmask_q <= wd;
    end
  end

  gpio_sync #(.WIDTH(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync)
  );

  assign din = sync ^ pol_q;

  gpio_edge #(.WIDTH(N)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (din),
    .wr_i    (wr_cause),
    .keep_i  (wd),
    .cause_o (cause)
  );

  gpio_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  assign pin_o    = (blink_q & {N{phase}}) | (~blink_q & out_q);
  assign pin_oe_o = ~dir_q;
  assign irq_o    = |((din & lmask_q) | (cause & emask_q));

  always_comb begin
    rdata_o = '0;
    if      (addr_i == A_OUT)   rdata_o[N-1:0] = out_q;
    else if (addr_i == A_DIR)   rdata_o[N-1:0] = dir_q;
    else if (addr_i == A_BLINK) rdata_o[N-1:0] = blink_q;
    else if (addr_i == A_POL)   rdata_o[N-1:0] = pol_q;
    else if (addr_i == A_DIN)   rdata_o[N-1:0] = din;
    else if (addr_i == A_CAUSE) rdata_o[N-1:0] = cause;
    else if (addr_i == A_EMASK) rdata_o[N-1:0] = emask_q;
    else if (addr_i == A_LMASK) rdata_o[N-1:0] = lmask_q;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned        N          = 32,
  parameter int unsigned        ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  CAUSE_ADDR = '0,
  parameter logic [ADDR_W-1:0]  DIR_ADDR   = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [N-1:0]      pin_o,
  input logic [N-1:0]      pin_oe_o,
  input logic              irq_o,
  input logic [N-1:0]      din_i,
  input logic [N-1:0]      cause_i,
  input logic [N-1:0]      blink_i,
  input logic [N-1:0]      emask_i,
  input logic [N-1:0]      lmask_i
);
  logic [N-1:0] din_d, rise_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) din_d <= '0;
    else         din_d <= din_i;
  end

  assign rise_c = din_i & ~din_d;

  // R2: a direction write is reflected in the enables one edge later
  a_r2_dir_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == DIR_ADDR) |=> (pin_oe_o == ~$past(wdata_i[N-1:0])));

  // R4: with both masks clear no request is possible
  a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emask_i == '0 && lmask_i == '0) |-> !irq_o);

  // R4: an enabled high level always requests
  a_r4_level_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(din_i & lmask_i)) |-> irq_o);

  // R5: clear-on-zero when no rising transition competes
  a_r5_zero_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CAUSE_ADDR && rise_c == '0)
      |=> (cause_i == $past(cause_i & wdata_i[N-1:0])));

  // R6, R9: a rising transition is always latched, even against a clear
  a_r6_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_c != '0) |=> ((cause_i & $past(rise_c)) == $past(rise_c)));

  // R8: without blink and without writes the pads hold
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_i == '0 && !we_i) |=> $stable(pin_o));
endmodule

bind gpio_bank gpio_bank_chk #(
  .N          (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .CAUSE_ADDR (A_CAUSE),
  .DIR_ADDR   (A_DIR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .din_i    (din),
  .cause_i  (cause),
  .blink_i  (blink_q),
  .emask_i  (emask_q),
  .lmask_i  (lmask_q)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NP   = 32;
  localparam int unsigned AW   = 8;
  localparam int unsigned MOFS = 32'h20;
  localparam int unsigned BDIV = 4;

  localparam logic [AW-1:0] A_OUT   = 8'h00;
  localparam logic [AW-1:0] A_DIR   = 8'h04;
  localparam logic [AW-1:0] A_BLINK = 8'h08;
  localparam logic [AW-1:0] A_POL   = 8'h0C;
  localparam logic [AW-1:0] A_DIN   = 8'h10;
  localparam logic [AW-1:0] A_CAUSE = 8'h14;
  localparam logic [AW-1:0] A_EMASK = AW'(32'h18 + MOFS);
  localparam logic [AW-1:0] A_LMASK = AW'(32'h1C + MOFS);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o, pin_oe_o;
  logic          irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW), .MASK_OFS(MOFS), .BLINK_DIV(BDIV)) u_gpio_bank (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic settle_clear();
    wait_n(4);
    wr(A_CAUSE, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_ni = 1'b0; pin_i = '0;
    wait_n(3);
    check("R1 oe", pin_oe_o, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    wait_n(1);
    peek(A_OUT, d);   check("R1 out", d, 32'h0);
    peek(A_DIR, d);   check("R1 dir", d, 32'hFFFF_FFFF);
    peek(A_BLINK, d); check("R1 blink", d, 32'h0);
    peek(A_POL, d);   check("R1 pol", d, 32'h0);
    peek(A_CAUSE, d); check("R1 cause", d, 32'h0);
    peek(A_EMASK, d); check("R1 emask", d, 32'h0);
    peek(A_LMASK, d); check("R1 lmask", d, 32'h0);
    check("R1 pin_o", pin_o, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] d;
    wr(A_OUT, 32'h0000_A5A5);
    wr(A_DIR, 32'hFFFF_0000);
    check("R2 oe", pin_oe_o, 32'h0000_FFFF);
    check("R2 drive", pin_o & pin_oe_o, 32'h0000_A5A5);
    peek(A_DIR, d); check("R2 dir readback", d, 32'hFFFF_0000);
    wr(A_DIR, 32'hFFFF_FFFF);
    check("R2 all inputs", pin_oe_o, 32'h0);
    wr(A_OUT, 32'h0);
  endtask

  task automatic t_datain();
    logic [31:0] d;
    pin_i = 32'h1234_5678;
    wait_n(3);
    peek(A_DIN, d); check("R3 raw", d, 32'h1234_5678);
    wr(A_POL, 32'h0000_FFFF);
    peek(A_DIN, d); check("R3 xor pol", d, 32'h1234_A987);
    wr(A_DIN, 32'hDEAD_BEEF);
    peek(A_DIN, d); check("R3 write ignored", d, 32'h1234_A987);
    wr(A_POL, 32'h0);
    pin_i = '0;
    settle_clear();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk_i);
    pin_i[5] = 1'b1;
    wait_n(2);
    peek(A_DIN, d);   check("R3 two-edge latency", d, 32'h20);
    peek(A_CAUSE, d); check("R6 not yet", d, 32'h0);
    wait_n(1);
    peek(A_CAUSE, d); check("R6 rise sets", d, 32'h20);
    wr(A_CAUSE, 32'h0);
    pin_i[5] = 1'b0;
    wait_n(4);
    peek(A_CAUSE, d); check("R6 fall ignored", d, 32'h0);
    pin_i[5] = 1'b1; pin_i[6] = 1'b1;
    wait_n(4);
    peek(A_CAUSE, d); check("R6 two bits", d, 32'h60);
    wr(A_CAUSE, 32'hFFFF_FFBF);
    peek(A_CAUSE, d); check("R5 zero clears", d, 32'h20);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    peek(A_CAUSE, d); check("R5 one keeps", d, 32'h20);
    wr(A_CAUSE, 32'h0);
    peek(A_CAUSE, d); check("R5 all clear", d, 32'h0);
    pin_i = '0;
    settle_clear();
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    wr(A_POL, 32'h08);
    wait_n(2);
    peek(A_CAUSE, d); check("R7 pol flip sets", d, 32'h08);
    pin_i[2] = 1'b1;
    settle_clear();
    wr(A_POL, 32'h0C);
    wait_n(2);
    wr(A_CAUSE, 32'h0);
    peek(A_CAUSE, d); check("R7 no rise on drop", d, 32'h0);
    pin_i[2] = 1'b0;
    wait_n(4);
    peek(A_CAUSE, d); check("R7 falling pin", d, 32'h04);
    wr(A_POL, 32'h0);
    pin_i = '0;
    settle_clear();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pin_i[0] = 1'b1;
    wait_n(4);
    peek(A_CAUSE, d); check("R9 setup", d, 32'h01);
    pin_i[1] = 1'b1;
    wait_n(1);
    wr(A_CAUSE, 32'h0);
    peek(A_CAUSE, d); check("R9 set wins", d, 32'h02);
    pin_i = '0;
    settle_clear();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_LMASK, 32'h10);
    check("R4 idle", {31'b0, irq_o}, 32'h0);
    pin_i[4] = 1'b1;
    wait_n(3);
    check("R4 level", {31'b0, irq_o}, 32'h1);
    pin_i[4] = 1'b0;
    wait_n(3);
    check("R4 level gone", {31'b0, irq_o}, 32'h0);
    peek(A_CAUSE, d); check("R4 cause latched", d, 32'h10);
    wr(A_EMASK, 32'h10);
    check("R4 edge", {31'b0, irq_o}, 32'h1);
    peek(8'h18, d); check("R10 moved mask", d, 32'h0);
    wr(A_CAUSE, 32'h0);
    check("R4 edge cleared", {31'b0, irq_o}, 32'h0);
    wr(A_EMASK, 32'h0);
    wr(A_LMASK, 32'h0);
  endtask

  task automatic t_blink();
    int toggles = 0;
    logic last;
    wr(A_DIR, ~32'h80);
    wr(A_OUT, 32'h80);
    wr(A_BLINK, 32'h80);
    check("R8 oe", pin_oe_o, 32'h80);
    last = pin_o[7];
    for (int i = 0; i < 8 * BDIV; i++) begin
      @(negedge clk_i);
      if (pin_o[7] != last) toggles++;
      last = pin_o[7];
    end
    check("R8 toggle count", toggles, 8);
    wr(A_BLINK, 32'h0);
    toggles = 0;
    for (int i = 0; i < 4 * BDIV; i++) begin
      @(negedge clk_i);
      if (pin_o[7] != 1'b1) toggles++;
    end
    check("R8 steady off", toggles, 0);
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_OUT, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(A_EMASK, 32'h5);
    peek(8'h1C, d); check("R10 0x1C", d, 32'h0);
    peek(8'h40, d); check("R10 0x40", d, 32'h0);
    peek(8'hFC, d); check("R10 0xFC", d, 32'h0);
    wr(A_EMASK, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_direction();
    t_datain();
    t_edge();
    t_polarity();
    t_set_wins();
    t_irq();
    t_blink();
    t_unmapped();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule